// File: doc/BRIEF.md
# Fetch Address Patch Unit

This block sits between program memory and a small CPU on the instruction-fetch path. It holds a set of programmable match addresses, two by default and each 24 bits wide. During a fetch it compares the fetch address with every enabled match address. On a hit, the opcode byte from memory is replaced by a fixed one-byte software-interrupt opcode (0x01). The CPU then enters an interrupt handler instead of running the original instruction, so firmware can patch code held in read-only memory at run time.

Software programs the block through a byte-wide register bus. Each channel's match address sits in three consecutive byte registers. A single control register holds one enable bit per channel. The comparators and the substitution mux are combinational, so the replaced byte reaches the CPU in the same cycle as the fetched byte. A per-channel hit output shows which channel fired.

Top module: `fetch_patch_unit`

## Requirements
- R1: Channel c, byte b (b=0 low, 1 middle, 2 high) is the read/write register at offset 0x1FF0 + 3*c + b. A write takes effect at the rising clock edge, and a read returns the stored byte combinationally on `reg_rdata`.
- R2: The control register at offset 0x009E reads 0x00 after reset. Reset does not clear the match-address bytes.
- R3: In the control register, bit 1 enables channel 0 and bit 3 enables channel 1. The other bits always read 0, and writing them has no effect.
- R4: When `fetch_valid` is 1 and `fetch_addr` equals the address of an enabled channel, `cpu_opcode` is 0x01 in the same cycle.
- R5: When a channel's address matches but its enable bit is 0, that channel does not change `cpu_opcode`.
- R6: When `fetch_valid` is 0, `cpu_opcode` equals `mem_opcode` and `match_hit` is 0, whatever the address.
- R7: When a valid fetch address matches no enabled channel, `cpu_opcode` equals `mem_opcode`.
- R8: When two enabled channels match at once, `cpu_opcode` is 0x01 and both `match_hit` bits are 1.
- R9: `match_hit[c]` is 1 exactly when `fetch_valid` is 1, channel c is enabled and `fetch_addr` equals channel c's address.
- R10: A write to an offset that maps to no register changes no register, and reading such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| fetch_addr | input | 24 | CPU fetch address |
| fetch_valid | input | 1 | Marks the cycle as an instruction fetch |
| mem_opcode | input | 8 | Byte returned by memory |
| cpu_opcode | output | 8 | Byte delivered to the CPU |
| match_hit | output | 2 | Per-channel hit indication |

## Verification
The assertions assume that the register bus never writes during reset. They also assume that every address byte of a channel has been written before that channel is enabled, because the bytes start undefined. The stimulus follows both rules. It loads all six address bytes first and only then writes the control register. Each write is a single-cycle strobe driven at the falling edge. Fetch inputs change only between edges, and outputs are sampled a short time after each change.

// File: rtl/fetch_patch_pkg.sv
package fetch_patch_pkg;

   localparam int BYTE_W      = 8;
   localparam int MAX_CH      = 4;

   // Enable bit position of channel c in the control byte (odd bits)
   function automatic int en_bit(input int c);
      return 2 * c + 1;
   endfunction

   // Gather the enable bits out of a control byte
   function automatic logic [MAX_CH-1:0] en_from_ctrl(input logic [BYTE_W-1:0] v);
      logic [MAX_CH-1:0] r;
      for (int c = 0; c < MAX_CH; c++) r[c] = v[en_bit(c)];
      return r;
   endfunction

endpackage

// File: rtl/fpu_addr_chan.sv
module fpu_addr_chan
   import fetch_patch_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int REG_AW   = 16,
   parameter int CH_BASE  = 16'h1FF0,
   parameter bit RESET_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              reg_we,
   output logic [ADDR_W-1:0] det_addr,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int NB = ADDR_W / BYTE_W;

   logic [NB-1:0]             sel;
   logic [NB-1:0][BYTE_W-1:0] q;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      logic [BYTE_W-1:0] byte_q;
      assign sel[b] = (reg_addr == REG_AW'(CH_BASE + b));
      if (RESET_EN) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                byte_q <= '0;
            else if (reg_we && sel[b]) byte_q <= reg_wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (reg_we && sel[b]) byte_q <= reg_wdata;
         end
      end
      assign q[b] = byte_q;
   end

   assign det_addr = q;

   always_comb begin
      rd_data = '0;
      for (int b = 0; b < NB; b++)
         if (sel[b]) rd_data = rd_data | q[b];
   end

   AST_ADDR_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && sel[0]) |=> (det_addr[BYTE_W-1:0] == $past(reg_wdata)));  // R1

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(reg_we && (|sel))) |=> $stable(det_addr));  // R10

endmodule

// File: rtl/fpu_ctrl_reg.sv
module fpu_ctrl_reg
   import fetch_patch_pkg::*;
#(
   parameter int NUM_CH    = 2,
   parameter int REG_AW    = 16,
   parameter int CTRL_ADDR = 16'h009E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              reg_we,
   output logic [NUM_CH-1:0] ch_en,
   output logic [BYTE_W-1:0] rd_data
);

   logic              sel;
   logic [MAX_CH-1:0] wr_all;
   logic [NUM_CH-1:0] wr_en;

   assign sel    = (reg_addr == REG_AW'(CTRL_ADDR));
   assign wr_all = en_from_ctrl(reg_wdata);
   assign wr_en  = wr_all[NUM_CH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ch_en <= '0;
      else if (reg_we && sel) ch_en <= wr_en;
   end

   always_comb begin
      rd_data = '0;
      if (sel)
         for (int c = 0; c < NUM_CH; c++) rd_data[en_bit(c)] = ch_en[c];
   end

   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && sel) |=> (ch_en == $past(wr_en)));  // R3

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(reg_we && sel)) |=> $stable(ch_en));  // R10

endmodule

// File: rtl/fpu_match_mux.sv
module fpu_match_mux #(
   parameter int          NUM_CH   = 2,
   parameter int          ADDR_W   = 24,
   parameter int          OP_W     = 8,
   parameter logic [7:0]  PATCH_OP = 8'h01
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CH-1:0][ADDR_W-1:0] det_addr,
   input  logic [NUM_CH-1:0]            ch_en,
   input  logic [ADDR_W-1:0]            fetch_addr,
   input  logic                         fetch_valid,
   input  logic [OP_W-1:0]              mem_opcode,
   output logic [OP_W-1:0]              cpu_opcode,
   output logic [NUM_CH-1:0]            match_hit
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
      assign match_hit[c] = fetch_valid && ch_en[c] && (fetch_addr == det_addr[c]);

      AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         match_hit[c] |-> ch_en[c]);  // R5
   end

   assign cpu_opcode = (|match_hit) ? OP_W'(PATCH_OP) : mem_opcode;

   AST_SUB_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (|match_hit) |-> (cpu_opcode == OP_W'(PATCH_OP)));  // R4

   AST_PASS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (match_hit == '0) |-> (cpu_opcode == mem_opcode));  // R7

   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid) |-> (match_hit == '0 && cpu_opcode == mem_opcode));  // R6

endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit
   import fetch_patch_pkg::*;
#(
   parameter int         NUM_CH        = 2,
   parameter int         ADDR_W        = 24,
   parameter int         REG_AW        = 16,
   parameter int         OP_W          = 8,
   parameter int         ADDR_BASE     = 16'h1FF0,
   parameter int         CTRL_ADDR     = 16'h009E,
   parameter logic [7:0] PATCH_OP      = 8'h01,
   parameter bit         ADDR_RESET_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   output logic [7:0]        reg_rdata,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_valid,
   input  logic [OP_W-1:0]   mem_opcode,
   output logic [OP_W-1:0]   cpu_opcode,
   output logic [NUM_CH-1:0] match_hit
);

   localparam int NB = ADDR_W / BYTE_W;

   if (ADDR_W % BYTE_W != 0 || ADDR_W < BYTE_W) begin : g_chk_aw
      $error("ADDR_W must be a whole number of bytes");
   end
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_chk_ch
      $error("NUM_CH must be between 1 and MAX_CH");
   end
   if (OP_W < 8) begin : g_chk_op
      $error("OP_W must hold the patch opcode");
   end

   logic [NUM_CH-1:0][ADDR_W-1:0] det_addr;
   logic [NUM_CH-1:0][BYTE_W-1:0] ch_rd;
   logic [NUM_CH-1:0]             ch_en;
   logic [BYTE_W-1:0]             ctrl_rd;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      fpu_addr_chan #(
         .ADDR_W   (ADDR_W),
         .REG_AW   (REG_AW),
         .CH_BASE  (ADDR_BASE + c * NB),
         .RESET_EN (ADDR_RESET_EN)
      ) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .reg_addr  (reg_addr),
         .reg_wdata (reg_wdata),
         .reg_we    (reg_we),
         .det_addr  (det_addr[c]),
         .rd_data   (ch_rd[c])
      );
   end

   fpu_ctrl_reg #(
      .NUM_CH    (NUM_CH),
      .REG_AW    (REG_AW),
      .CTRL_ADDR (CTRL_ADDR)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .ch_en     (ch_en),
      .rd_data   (ctrl_rd)
   );

   always_comb begin
      reg_rdata = ctrl_rd;
      for (int c = 0; c < NUM_CH; c++) reg_rdata = reg_rdata | ch_rd[c];
   end

   fpu_match_mux #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .OP_W     (OP_W),
      .PATCH_OP (PATCH_OP)
   ) i_mux (
      .clk         (clk),
      .rst_n       (rst_n),
      .det_addr    (det_addr),
      .ch_en       (ch_en),
      .fetch_addr  (fetch_addr),
      .fetch_valid (fetch_valid),
      .mem_opcode  (mem_opcode),
      .cpu_opcode  (cpu_opcode),
      .match_hit   (match_hit)
   );

   AST_BOTH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(match_hit) > 1) |-> (cpu_opcode == OP_W'(PATCH_OP)));  // R8

endmodule

// File: tb/test_fetch_patch_unit.sv
module test_fetch_patch_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [23:0] A0 = 24'h123456;
   localparam logic [23:0] A1 = 24'hABCDEF;

   // {ctrl, valid, addr, mem, exp_op, exp_hit}
   localparam int VW = 51;
   localparam int NV = 12;
   localparam logic [VW-1:0] VEC [NV] = '{
      {8'h00, 1'b1, A0,         8'h5A, 8'h5A, 2'b00},  // R5 ch0 off
      {8'h02, 1'b1, A0,         8'h5A, 8'h01, 2'b01},  // R4
      {8'h02, 1'b1, A1,         8'h77, 8'h77, 2'b00},  // R5 ch1 off
      {8'h08, 1'b1, A1,         8'h77, 8'h01, 2'b10},  // R4
      {8'h08, 1'b1, A0,         8'h33, 8'h33, 2'b00},  // R5
      {8'h0A, 1'b0, A0,         8'h44, 8'h44, 2'b00},  // R6
      {8'h0A, 1'b1, 24'h123457, 8'h99, 8'h99, 2'b00},  // R7
      {8'h0A, 1'b1, A1,         8'h00, 8'h01, 2'b10},  // R9
      {8'h0A, 1'b1, A0,         8'hFF, 8'h01, 2'b01},  // R9
      {8'hF5, 1'b1, A0,         8'h22, 8'h22, 2'b00},  // R3 reserved only
      {8'hFF, 1'b1, A1,         8'h01, 8'h01, 2'b10},  // R3
      {8'h0A, 1'b1, 24'hABCDEE, 8'h10, 8'h10, 2'b00}   // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_rdata;
   logic [23:0] fetch_addr = '0;
   logic        fetch_valid = 1'b0;
   logic [7:0]  mem_opcode = '0;
   logic [7:0]  cpu_opcode;
   logic [1:0]  match_hit;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fetch_patch_unit i_fetch_patch_unit (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
      .fetch_valid(fetch_valid), .mem_opcode(mem_opcode),
      .cpu_opcode(cpu_opcode), .match_hit(match_hit)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      check(req, 32'(reg_rdata), 32'(exp));
   endtask

   task automatic fetch_chk(input string req, input logic v, input logic [23:0] a,
                            input logic [7:0] m, input logic [7:0] eo, input logic [1:0] eh);
      fetch_valid = v; fetch_addr = a; mem_opcode = m;
      #1;
      check(req, 32'(cpu_opcode), 32'(eo));
      check(req, 32'(match_hit), 32'(eh));
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R2 ctrl after reset", 16'h009E, 8'h00);
      fetch_chk("R2 no enable after reset", 1'b1, A0, 8'h6C, 8'h6C, 2'b00);

      // Load both channels: ch c byte b at 0x1FF0 + 3c + b
      wr(16'h1FF0, A0[7:0]);  wr(16'h1FF1, A0[15:8]);  wr(16'h1FF2, A0[23:16]);
      wr(16'h1FF3, A1[7:0]);  wr(16'h1FF4, A1[15:8]);  wr(16'h1FF5, A1[23:16]);
      rd_chk("R1 ch0 low",  16'h1FF0, 8'h56);
      rd_chk("R1 ch0 mid",  16'h1FF1, 8'h34);
      rd_chk("R1 ch0 high", 16'h1FF2, 8'h12);
      rd_chk("R1 ch1 low",  16'h1FF3, 8'hEF);
      rd_chk("R1 ch1 mid",  16'h1FF4, 8'hCD);
      rd_chk("R1 ch1 high", 16'h1FF5, 8'hAB);

      for (int i = 0; i < NV; i++) begin
         wr(16'h009E, VEC[i][50:43]);
         fetch_chk($sformatf("R4-R9 vector %0d", i), VEC[i][42], VEC[i][41:18],
                   VEC[i][17:10], VEC[i][9:2], VEC[i][1:0]);
      end

      // Reserved bits read 0
      wr(16'h009E, 8'hFF);
      rd_chk("R3 reserved read zero", 16'h009E, 8'h0A);
      wr(16'h009E, 8'hF5);
      rd_chk("R3 reserved write ignored", 16'h009E, 8'h00);

      // Unmapped writes
      wr(16'h009E, 8'h0A);
      wr(16'h1FF6, 8'hC3);
      wr(16'h1FEF, 8'h3C);
      wr(16'h009F, 8'h00);
      rd_chk("R10 unmapped read", 16'h1FF6, 8'h00);
      rd_chk("R10 ch0 low kept", 16'h1FF0, 8'h56);
      rd_chk("R10 ch1 high kept", 16'h1FF5, 8'hAB);
      rd_chk("R10 ctrl kept", 16'h009E, 8'h0A);

      // Both channels on the same address
      wr(16'h1FF3, A0[7:0]);  wr(16'h1FF4, A0[15:8]);  wr(16'h1FF5, A0[23:16]);
      fetch_chk("R8 dual match", 1'b1, A0, 8'hE7, 8'h01, 2'b11);
      fetch_chk("R6 dual match no fetch", 1'b0, A0, 8'hE7, 8'hE7, 2'b00);

      // Reset clears enables but keeps the address bytes
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R2 ctrl after second reset", 16'h009E, 8'h00);
      fetch_chk("R2 pass after second reset", 1'b1, A0, 8'h5E, 8'h5E, 2'b00);
      rd_chk("R2 address survives reset", 16'h1FF1, 8'h34);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule